// File: doc/BRIEF.md
# Intra-Prediction Pixel Block Generator

This block builds the predicted pixels of a 4x4 square block from neighbour samples that were already reconstructed: a row of four pixels above the block, a column of four pixels to its left, and the single pixel at the top-left corner. There are three prediction modes. Horizontal mode copies the left column across each row. Vertical mode copies the top row down each column. True-motion mode adds the left and top neighbours, subtracts the corner, and clamps the result to the 8-bit pixel range. All pixels are 8-bit unsigned values, where 0 is black and 255 is white.

A one-cycle start pulse, given while the block is idle, captures the mode and all neighbour inputs. On the following 16 cycles the block emits one pixel per clock in raster order. Each pixel comes with its row and column index and a valid strobe. The neighbour inputs may change freely once they have been captured. A start that arrives while a block is still being emitted is dropped.

Top module: `intra_pred_gen`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, valid_o is 0, pix_o is 0, row_o is 0 and col_o is 0.
- R2: A start_i sampled high at a clock edge where valid_o is low captures mode_i, top_i, left_i and corner_i. From the next cycle on, valid_o stays high for exactly 16 consecutive cycles. Input changes after the capture edge do not affect the burst.
- R3: During a burst, pixels come out in raster order. row_o and col_o start at (0,0), col_o advances first, and the burst ends at (3,3).
- R4: Mode 0 (horizontal): pixel (i,j) equals left pixel i. Neighbour pixel k sits in bits [8k+7:8k] of left_i and of top_i.
- R5: Mode 1 (vertical): pixel (i,j) equals top pixel j.
- R6: Mode 2 (true-motion): pixel (i,j) equals left[i] + top[j] - corner whenever that sum lies in 0..255.
- R7: Mode 2: a negative true-motion sum gives 0.
- R8: Mode 2: a true-motion sum above 255 gives 255.
- R9: Mode 3 is reserved, and every pixel it produces is 0.
- R10: A start_i that is high while valid_o is high is ignored. This holds on the last pixel's edge too. The running burst keeps its captured inputs and its length, and no new burst follows.
- R11: pix_o is 0 on every cycle where valid_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; captures the inputs when the block is idle |
| mode_i | input | 2 | 0 horizontal, 1 vertical, 2 true-motion, 3 reserved |
| top_i | input | 32 | Row above the block, pixel k in bits [8k+7:8k] |
| left_i | input | 32 | Column to the left of the block, pixel k in bits [8k+7:8k] |
| corner_i | input | 8 | Top-left corner pixel |
| valid_o | output | 1 | High while a predicted pixel is presented |
| pix_o | output | 8 | Predicted pixel value |
| row_o | output | 2 | Row index of the presented pixel |
| col_o | output | 2 | Column index of the presented pixel |

## Verification
On every cycle, the assertions check the burst framing:
- a start while idle always opens a burst on the next cycle;
- a burst lasts exactly 16 cycles;
- the row and column indices begin at the origin and step by one in raster order;
- a start during a burst never restarts it;
- pix_o is zero while idle.

The pixel values themselves are shown only by the bench's scenarios. These scenarios compare each emitted pixel against a model of the three modes. They include all-white and all-black neighbours that drive the sum past both saturation limits, mixed patterns that clamp only some pixels, the reserved mode, and inputs scrambled after capture. Only these scenarios can show that a start during a burst leaves the captured values in use.

// File: rtl/intra_pkg.sv
package intra_pkg;
  typedef enum logic [1:0] {
    MODE_HOR = 2'd0,
    MODE_VER = 2'd1,
    MODE_TM  = 2'd2,
    MODE_RSV = 2'd3
  } pred_mode_e;
endpackage

// File: rtl/intra_seq.sv
module intra_seq #(
  parameter int NPIX = 16,
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             load_o,
  output logic             active_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIX - 1);

  logic             active_q;
  logic [IDX_W-1:0] idx_q;

  assign load_o   = start_i & ~active_q;
  assign active_o = active_q;
  assign idx_o    = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      idx_q    <= '0;
    end else if (load_o) begin
      active_q <= 1'b1;
      idx_q    <= '0;
    end else if (active_q) begin
      if (idx_q == LAST) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/intra_nbr_reg.sv
module intra_nbr_reg
  import intra_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int PIX_W = 8,
  localparam int VEC_W = BLK * PIX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [1:0]       mode_i,
  input  logic [VEC_W-1:0] top_i,
  input  logic [VEC_W-1:0] left_i,
  input  logic [PIX_W-1:0] corner_i,
  output pred_mode_e       mode_o,
  output logic [VEC_W-1:0] top_o,
  output logic [VEC_W-1:0] left_o,
  output logic [PIX_W-1:0] corner_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_o   <= MODE_HOR;
      top_o    <= '0;
      left_o   <= '0;
      corner_o <= '0;
    end else if (load_i) begin
      mode_o   <= pred_mode_e'(mode_i);
      top_o    <= top_i;
      left_o   <= left_i;
      corner_o <= corner_i;
    end
  end
endmodule

// File: rtl/intra_pix_calc.sv
module intra_pix_calc
  import intra_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int PIX_W = 8,
  localparam int VEC_W = BLK * PIX_W,
  localparam int RC_W  = $clog2(BLK),
  localparam int SUM_W = PIX_W + 2
) (
  input  logic             en_i,
  input  pred_mode_e       mode_i,
  input  logic [VEC_W-1:0] top_i,
  input  logic [VEC_W-1:0] left_i,
  input  logic [PIX_W-1:0] corner_i,
  input  logic [RC_W-1:0]  row_i,
  input  logic [RC_W-1:0]  col_i,
  output logic [PIX_W-1:0] pix_o
);
  localparam logic signed [SUM_W-1:0] PIX_MAX = SUM_W'({PIX_W{1'b1}});

  logic [PIX_W-1:0] top_a  [BLK];
  logic [PIX_W-1:0] left_a [BLK];

  for (genvar g = 0; g < BLK; g++) begin : g_unpack
    assign top_a[g]  = top_i[g*PIX_W +: PIX_W];
    assign left_a[g] = left_i[g*PIX_W +: PIX_W];
  end

  logic [PIX_W-1:0]        t_pix, l_pix, tm_pix;
  logic signed [SUM_W-1:0] tm_sum;

  assign t_pix = top_a[col_i];
  assign l_pix = left_a[row_i];

  // signed sum wide enough for -max..2*max before clamping
  assign tm_sum = $signed({2'b00, l_pix}) + $signed({2'b00, t_pix})
                - $signed({2'b00, corner_i});

  always_comb begin
    if (tm_sum < 0)            tm_pix = '0;
    else if (tm_sum > PIX_MAX) tm_pix = '1;
    else                       tm_pix = tm_sum[PIX_W-1:0];
  end

  always_comb begin
    pix_o = '0;
    if (en_i) begin
      unique case (mode_i)
        MODE_HOR: pix_o = l_pix;
        MODE_VER: pix_o = t_pix;
        MODE_TM:  pix_o = tm_pix;
        default:  pix_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/intra_pred_gen.sv
module intra_pred_gen
  import intra_pkg::*;
#(
  parameter int BLK   = 4,
  parameter int PIX_W = 8,
  localparam int VEC_W = BLK * PIX_W,
  localparam int NPIX  = BLK * BLK,
  localparam int RC_W  = $clog2(BLK),
  localparam int IDX_W = $clog2(NPIX)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       mode_i,
  input  logic [VEC_W-1:0] top_i,
  input  logic [VEC_W-1:0] left_i,
  input  logic [PIX_W-1:0] corner_i,
  output logic             valid_o,
  output logic [PIX_W-1:0] pix_o,
  output logic [RC_W-1:0]  row_o,
  output logic [RC_W-1:0]  col_o
);
  logic             load, active;
  logic [IDX_W-1:0] idx;
  pred_mode_e       mode_q;
  logic [VEC_W-1:0] top_q, left_q;
  logic [PIX_W-1:0] corner_q;

  intra_seq #(.NPIX(NPIX)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .load_o  (load),
    .active_o(active),
    .idx_o   (idx)
  );

  intra_nbr_reg #(.BLK(BLK), .PIX_W(PIX_W)) u_nbr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .mode_i  (mode_i),
    .top_i   (top_i),
    .left_i  (left_i),
    .corner_i(corner_i),
    .mode_o  (mode_q),
    .top_o   (top_q),
    .left_o  (left_q),
    .corner_o(corner_q)
  );

  assign row_o   = idx[IDX_W-1:RC_W];
  assign col_o   = idx[RC_W-1:0];
  assign valid_o = active;

  intra_pix_calc #(.BLK(BLK), .PIX_W(PIX_W)) u_calc (
    .en_i    (active),
    .mode_i  (mode_q),
    .top_i   (top_q),
    .left_i  (left_q),
    .corner_i(corner_q),
    .row_i   (row_o),
    .col_i   (col_o),
    .pix_o   (pix_o)
  );
endmodule

// File: rtl/intra_pred_chk.sv
module intra_pred_chk #(
  parameter int BLK   = 4,
  parameter int PIX_W = 8,
  localparam int NPIX  = BLK * BLK,
  localparam int RC_W  = $clog2(BLK),
  localparam int IDX_W = $clog2(NPIX),
  localparam int CNT_W = IDX_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             valid_o,
  input logic [PIX_W-1:0] pix_o,
  input logic [RC_W-1:0]  row_o,
  input logic [RC_W-1:0]  col_o
);
  logic [CNT_W-1:0] run_cnt;
  logic [IDX_W-1:0] pos;
  assign pos = {row_o, col_o};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      run_cnt <= '0;
    else if (valid_o) run_cnt <= run_cnt + 1'b1;
    else              run_cnt <= '0;
  end

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !valid_o) |=> valid_o);

  // R2
  burst_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> run_cnt < CNT_W'(NPIX));

  // R2
  burst_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> run_cnt == CNT_W'(NPIX));

  // R3
  raster_origin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> pos == '0);

  // R3
  raster_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> pos == IDX_W'($past(pos) + 1'b1));

  // R10
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && start_i && pos != '1) |=> (valid_o && pos != '0));

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> pix_o == '0);
endmodule

bind intra_pred_gen intra_pred_chk #(.BLK(BLK), .PIX_W(PIX_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .valid_o(valid_o),
  .pix_o  (pix_o),
  .row_o  (row_o),
  .col_o  (col_o)
);

// File: tb/intra_pred_gen_tb.sv
module intra_pred_gen_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  mode_i = '0;
  logic [31:0] top_i = '0;
  logic [31:0] left_i = '0;
  logic [7:0]  corner_i = '0;
  logic        valid_o;
  logic [7:0]  pix_o;
  logic [1:0]  row_o, col_o;

  int checks = 0;
  int errors = 0;

  always #10 clk_i = ~clk_i;

  intra_pred_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i),
    .top_i(top_i), .left_i(left_i), .corner_i(corner_i),
    .valid_o(valid_o), .pix_o(pix_o), .row_o(row_o), .col_o(col_o)
  );

  // {mode, top, left, corner}
  localparam logic [73:0] VECS [8] = '{
    {2'd0, 32'h11223344, 32'h0a0b0c0d, 8'h00},
    {2'd1, 32'h11223344, 32'h0a0b0c0d, 8'h00},
    {2'd2, 32'h40302010, 32'h04030201, 8'h08},
    {2'd2, 32'hffffffff, 32'hffffffff, 8'h00},
    {2'd2, 32'h00000000, 32'h00000000, 8'hff},
    {2'd2, 32'hff00ff00, 32'h00ff00ff, 8'h80},
    {2'd3, 32'haaaaaaaa, 32'h55555555, 8'h11},
    {2'd2, 32'hff00ff00, 32'hffff0000, 8'hff}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int raw_tm(input logic [73:0] v, input int i, input int j);
    int l, t, c;
    l = int'(v[8 + 8*i +: 8]);
    t = int'(v[40 + 8*j +: 8]);
    c = int'(v[7:0]);
    return l + t - c;
  endfunction

  task automatic chk_pix(input logic [73:0] v, input int k);
    int i, j, e, r;
    string tag;
    i = k / 4;
    j = k % 4;
    chk(valid_o === 1'b1, "R2 valid in burst", int'(valid_o), 1);
    chk(row_o == 2'(i) && col_o == 2'(j), "R3 raster position",
        int'({row_o, col_o}), k);
    case (v[73:72])
      2'd0: begin e = int'(v[8 + 8*i +: 8]); tag = "R4 horizontal"; end
      2'd1: begin e = int'(v[40 + 8*j +: 8]); tag = "R5 vertical"; end
      2'd2: begin
        r = raw_tm(v, i, j);
        if (r < 0)        begin e = 0;   tag = "R7 underflow"; end
        else if (r > 255) begin e = 255; tag = "R8 overflow"; end
        else              begin e = r;   tag = "R6 true-motion"; end
      end
      default: begin e = 0; tag = "R9 reserved"; end
    endcase
    chk(int'(pix_o) == e, tag, int'(pix_o), e);
  endtask

  // busy_k: pixel index at which a start is raised during the burst (-1 none)
  task automatic run_burst(input logic [73:0] v, input int busy_k);
    @(negedge clk_i);
    {mode_i, top_i, left_i, corner_i} = v;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    {mode_i, top_i, left_i, corner_i} = ~v;  // R2: scrambled after capture
    for (int k = 0; k < 16; k++) begin
      chk_pix(v, k);
      start_i = (k == busy_k);
      @(negedge clk_i);
    end
    chk(valid_o === 1'b0, "R2 burst ends after 16", int'(valid_o), 0);
    chk(pix_o == 8'd0, "R11 idle pixel zero", int'(pix_o), 0);
    start_i = 1'b0;
    if (busy_k >= 0) begin
      @(negedge clk_i);
      chk(valid_o === 1'b0, "R10 no burst after busy start", int'(valid_o), 0);
    end
  endtask

  initial begin
    #10;
    chk(valid_o === 1'b0 && pix_o == 8'd0, "R1 reset outputs",
        int'({valid_o, pix_o}), 0);
    chk(row_o == 2'd0 && col_o == 2'd0, "R1 reset position",
        int'({row_o, col_o}), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(valid_o === 1'b0, "R1 idle after reset", int'(valid_o), 0);
    chk(pix_o == 8'd0, "R11 idle after reset", int'(pix_o), 0);

    for (int n = 0; n < 8; n++) run_burst(VECS[n], -1);

    // R10: start mid-burst with different inputs, then on the last pixel
    run_burst(VECS[2], 5);
    run_burst(VECS[5], 15);
    run_burst(VECS[7], -1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule